// File: doc/BRIEF.md
# Sized integer ALU with status flags and branch-condition evaluation

This block is the integer arithmetic stage of a processor datapath. Each operation works on the low 8, 16 or 32 bits of two operands, chosen per operation, and performs add, subtract, compare, increment, decrement, negate, AND or OR. It yields the sized result at once, along with a write-back qualifier that is low for compare.

Alongside the result it forms six status flags: carry, overflow, sign, zero, half carry (bit 3 to bit 4) and low-byte parity. They enter a flags register on a clock edge when the load enable is high.

A separate 4-bit condition input is evaluated against the registered flags. It answers whether a conditional branch with that code would be taken, so a sequencer can compare first and branch a cycle later.

Top module: `flag_alu`

## Requirements
- R1: `op_i` encodes 0 add, 1 subtract (a-b), 2 compare, 3 increment a, 4 decrement a, 5 negate a, 6 AND, 7 OR. `size_i` encodes 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. `result_o` is the operation's value modulo the selected width, with all bits above the width zero. Operand bits above the width have no effect. `result_o` and `wr_valid_o` are combinational.
- R2: The carry flag is set as follows. For add, it marks an unsigned carry out of the width. For subtract and compare, it marks a borrow (unsigned a < b). For negate, it is set when the sized operand is nonzero. AND and OR clear it.
- R3: The sign flag equals the top bit of the sized result. The zero flag is set when the sized result is all zeros.
- R4: The overflow flag is set when the signed result does not fit the width: for example, 8-bit 7Eh+2 gives 80h with overflow, and 8-bit 80h-2 gives 7Eh with overflow. AND and OR clear it.
- R5: The half-carry flag marks a carry out of bit 3 on add and increment. It marks a borrow into bit 3 on subtract, compare, decrement and negate. AND and OR clear it.
- R6: The parity flag is set when the low 8 bits of the result hold an even number of ones, whatever the width.
- R7: Increment and decrement update every flag except carry, which keeps its registered value (16-bit FFFFh+1 gives zero set, carry unchanged).
- R8: Compare loads the same flags as subtract, and `wr_valid_o` is low for compare and high for all other operations.
- R9: `flags_o` carries carry in bit 0, parity in bit 1, half carry in bit 2, zero in bit 3, sign in bit 4 and overflow in bit 5. It loads on a rising clock edge when `load_i` is high, holds otherwise, and clears to zero on reset.
- R10: `cond_true_o` is combinational from `cond_i` and the registered flags. The codes are: 0 overflow, 2 carry, 4 zero, 6 carry or zero, 8 sign, 10 parity, 12 sign differs from overflow, 14 zero or sign differs from overflow. Each odd code is the inverse of the even code below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select |
| size_i | input | 2 | Operand width select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| load_i | input | 1 | Flags register load enable |
| cond_i | input | 4 | Branch condition code |
| result_o | output | 32 | Sized result |
| wr_valid_o | output | 1 | Result is meant for write-back |
| flags_o | output | 6 | Registered status flags |
| cond_true_o | output | 1 | Condition holds on registered flags |

## Verification
The result and write-back qualifier are due in the same cycle as the operands. The bench therefore samples them shortly after driving at the falling edge. The flags are due after the first rising edge with the load enable high, so they are checked at the following falling edge. The condition output follows the registered flags with no clock, so all sixteen codes are swept with short delays inside that same low half-period while the load enable is held low. An exhaustive sweep over operations, widths and eight boundary operands, with junk above the width, compares every value against arithmetic done on wide integers in the bench.

// File: rtl/alu_flags_pkg.sv
`timescale 1ns/10ps
package alu_flags_pkg;

  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 6;
  localparam int COND_W = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_NEG = 3'd5,
    OP_AND = 3'd6,
    OP_OR  = 3'd7
  } alu_op_e;

  // bit order gives carry at bit 0 through overflow at bit 5
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = {{(WORD_W-8){1'b0}}, {8{1'b1}}};
      2'd1:    size_mask = {{(WORD_W-16){1'b0}}, {16{1'b1}}};
      default: size_mask = {WORD_W{1'b1}};
    endcase
  endfunction

  function automatic logic sized_msb(input logic [WORD_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    sized_msb = v[7];
      2'd1:    sized_msb = v[15];
      default: sized_msb = v[WORD_W-1];
    endcase
  endfunction

  // bit just above the selected width of a widened sum or difference
  function automatic logic carry_at(input logic [WORD_W:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    carry_at = v[8];
      2'd1:    carry_at = v[16];
      default: carry_at = v[WORD_W];
    endcase
  endfunction

  function automatic logic even_ones(input logic [BYTE_W-1:0] v);
    even_ones = ~(^v);
  endfunction

endpackage

// File: rtl/alu_core.sv
`timescale 1ns/10ps
module alu_core
  import alu_flags_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] result_o,
  output flags_t            nxt_flags_o,
  output logic              keep_cf_o,
  output logic              writes_o
);

  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] a_m, b_m;
  logic [WORD_W-1:0] x_opnd, y_opnd;
  logic              do_sub;
  logic              is_logic;
  logic [WORD_W:0]   arith_raw;
  logic [WORD_W-1:0] logic_res;
  logic [WORD_W-1:0] sized_res;

  // named internal events
  logic carry_out_w;
  logic half_carry_w;
  logic signed_ovf_w;

  assign mask = size_mask(size_i);
  assign a_m  = a_i & mask;
  assign b_m  = b_i & mask;

  always_comb begin
    x_opnd   = a_m;
    y_opnd   = b_m;
    do_sub   = 1'b0;
    is_logic = 1'b0;
    case (alu_op_e'(op_i))
      OP_ADD: ;
      OP_SUB, OP_CMP: do_sub = 1'b1;
      OP_INC: y_opnd = {{(WORD_W-1){1'b0}}, 1'b1};
      OP_DEC: begin
        y_opnd = {{(WORD_W-1){1'b0}}, 1'b1};
        do_sub = 1'b1;
      end
      OP_NEG: begin
        x_opnd = '0;
        y_opnd = a_m;
        do_sub = 1'b1;
      end
      default: is_logic = 1'b1;
    endcase
  end

  assign arith_raw = do_sub ? ({1'b0, x_opnd} - {1'b0, y_opnd})
                            : ({1'b0, x_opnd} + {1'b0, y_opnd});
  assign logic_res = (op_i == OP_AND) ? (a_m & b_m) : (a_m | b_m);
  assign sized_res = is_logic ? logic_res : (arith_raw[WORD_W-1:0] & mask);

  assign carry_out_w  = carry_at(arith_raw, size_i);
  assign half_carry_w = x_opnd[NIB_W] ^ y_opnd[NIB_W] ^ arith_raw[NIB_W];

  always_comb begin
    logic sx, sy, sr;
    sx = sized_msb(x_opnd, size_i);
    sy = sized_msb(y_opnd, size_i);
    sr = sized_msb(sized_res, size_i);
    if (do_sub) signed_ovf_w = (sx != sy) && (sr != sx);
    else        signed_ovf_w = (sx == sy) && (sr != sx);
  end

  always_comb begin
    nxt_flags_o.cf = is_logic ? 1'b0 : carry_out_w;
    nxt_flags_o.of = is_logic ? 1'b0 : signed_ovf_w;
    nxt_flags_o.af = is_logic ? 1'b0 : half_carry_w;
    nxt_flags_o.sf = sized_msb(sized_res, size_i);
    nxt_flags_o.zf = (sized_res == '0);
    nxt_flags_o.pf = even_ones(sized_res[BYTE_W-1:0]);
  end

  assign result_o  = sized_res;
  assign keep_cf_o = (op_i == OP_INC) || (op_i == OP_DEC);
  assign writes_o  = (op_i != OP_CMP);

endmodule

// File: rtl/flag_reg.sv
`timescale 1ns/10ps
module flag_reg
  import alu_flags_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   keep_cf_i,
  input  flags_t nxt_i,
  output flags_t q_o
);

  flags_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_i) begin
      q    <= nxt_i;
      q.cf <= keep_cf_i ? q.cf : nxt_i.cf;
    end
  end

  assign q_o = q;

  // R7: carry survives increment and decrement
  a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && keep_cf_i) |=> (q.cf == $past(q.cf)));

  // R9: no load, no change
  a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q));

endmodule

// File: rtl/cond_eval.sv
`timescale 1ns/10ps
module cond_eval
  import alu_flags_pkg::*;
(
  input  flags_t            flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              taken_o
);

  logic base;
  logic sign_ne_ovf;

  assign sign_ne_ovf = flags_i.sf ^ flags_i.of;

  always_comb begin
    case (cond_i[COND_W-1:1])
      3'd0:    base = flags_i.of;
      3'd1:    base = flags_i.cf;
      3'd2:    base = flags_i.zf;
      3'd3:    base = flags_i.cf | flags_i.zf;
      3'd4:    base = flags_i.sf;
      3'd5:    base = flags_i.pf;
      3'd6:    base = sign_ne_ovf;
      default: base = flags_i.zf | sign_ne_ovf;
    endcase
  end

  assign taken_o = base ^ cond_i[0];

endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/10ps
module flag_alu
  import alu_flags_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic [1:0]          size_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  input  logic                load_i,
  input  logic [COND_W-1:0]   cond_i,
  output logic [WORD_W-1:0]   result_o,
  output logic                wr_valid_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                cond_true_o
);

  flags_t nxt_flags;
  flags_t cur_flags;
  logic   keep_cf;

  alu_core u_core (
    .op_i        (op_i),
    .size_i      (size_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .result_o    (result_o),
    .nxt_flags_o (nxt_flags),
    .keep_cf_o   (keep_cf),
    .writes_o    (wr_valid_o)
  );

  flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .keep_cf_i (keep_cf),
    .nxt_i     (nxt_flags),
    .q_o       (cur_flags)
  );

  cond_eval u_cond (
    .flags_i (cur_flags),
    .cond_i  (cond_i),
    .taken_o (cond_true_o)
  );

  assign flags_o = cur_flags;

  // R3: registered zero flag agrees with the result seen at load
  a_r3_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (flags_o[3] == ($past(result_o) == '0)));

  // R6: registered parity agrees with the low byte seen at load
  a_r6_parity_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (flags_o[1] == even_ones($past(result_o[BYTE_W-1:0]))));

  // R8: a compare of a smaller unsigned value leaves a borrow
  a_r8_compare_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && op_i == OP_CMP && ((a_i & size_mask(size_i)) < (b_i & size_mask(size_i))))
      |=> flags_o[0]);

endmodule

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/10ps
module flag_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        load_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [31:0] result_o;
  logic        wr_valid_o;
  logic [5:0]  flags_o;
  logic        cond_true_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] mflags = '0;

  always #2 clk = ~clk;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i), .a_i(a_i), .b_i(b_i),
    .load_i(load_i), .cond_i(cond_i), .result_o(result_o), .wr_valid_o(wr_valid_o),
    .flags_o(flags_o), .cond_true_o(cond_true_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%0d size=%0d a=%h b=%h)",
               req, act, exp, op_i, size_i, a_i, b_i);
    end
  endtask

  function automatic int width_of(input int sz);
    return (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
  endfunction

  // reference arithmetic on wide integers
  task automatic model(input int op, input int sz, input logic [31:0] a, input logic [31:0] b,
                       input logic prev_cf, output logic [31:0] r, output logic [5:0] f);
    longint m, ua, ub, sa, sb, full, sfull, rr;
    logic cf, of, af, zf, sf, pf;
    int ones;
    m  = longint'(1) << width_of(sz);
    ua = longint'(a) & (m - 1);
    ub = longint'(b) & (m - 1);
    sa = (ua >= m / 2) ? ua - m : ua;
    sb = (ub >= m / 2) ? ub - m : ub;
    sfull = 0;
    cf = 0; af = 0;
    case (op)
      0: begin full = ua + ub; sfull = sa + sb; cf = full >= m; af = (ua % 16 + ub % 16) >= 16; end
      1, 2: begin full = ua - ub; sfull = sa - sb; cf = ua < ub; af = (ua % 16) < (ub % 16); end
      3: begin full = ua + 1; sfull = sa + 1; cf = prev_cf; af = (ua % 16) == 15; end
      4: begin full = ua - 1; sfull = sa - 1; cf = prev_cf; af = (ua % 16) == 0; end
      5: begin full = -ua; sfull = -sa; cf = ua != 0; af = (ua % 16) != 0; end
      6: full = ua & ub;
      default: full = ua | ub;
    endcase
    of = (sfull > m / 2 - 1) || (sfull < -(m / 2));
    rr = full & (m - 1);
    zf = (rr == 0);
    sf = (rr >= m / 2);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(rr[i]);
    pf = (ones % 2) == 0;
    r = 32'(rr);
    f = {of, sf, zf, af, pf, cf};
  endtask

  function automatic logic exp_cond(input logic [5:0] f, input int c);
    logic cf, pf, zf, sf, of, base;
    cf = f[0]; pf = f[1]; zf = f[3]; sf = f[4]; of = f[5];
    case (c / 2)
      0: base = of;
      1: base = cf;
      2: base = zf;
      3: base = cf | zf;
      4: base = sf;
      5: base = pf;
      6: base = sf != of;
      default: base = zf | (sf != of);
    endcase
    return (c % 2 == 1) ? !base : base;
  endfunction

  task automatic sweep_conds();
    for (int c = 0; c < 16; c++) begin
      cond_i = 4'(c);
      #0.05;
      check("R10 cond", 32'(cond_true_o), 32'(exp_cond(mflags, c)));
    end
  endtask

  task automatic apply(input int op, input int sz, input logic [31:0] a, input logic [31:0] b,
                       input logic ld);
    logic [31:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    op_i = 3'(op); size_i = 2'(sz); a_i = a; b_i = b; load_i = ld;
    model(op, sz, a, b, mflags[0], er, ef);
    #0.3;
    check("R1 result", result_o, er);
    check("R8 wr_valid", 32'(wr_valid_o), 32'(op != 2));
    @(negedge clk);
    load_i = 1'b0;
    if (ld) mflags = ef;
    if (op == 3 || op == 4) check("R7 carry kept", 32'(flags_o[0]), 32'(mflags[0]));
    else if (op == 2)       check("R8 cmp carry", 32'(flags_o[0]), 32'(mflags[0]));
    else                    check("R2 carry", 32'(flags_o[0]), 32'(mflags[0]));
    check("R6 parity", 32'(flags_o[1]), 32'(mflags[1]));
    check("R5 half carry", 32'(flags_o[2]), 32'(mflags[2]));
    check("R3 zero", 32'(flags_o[3]), 32'(mflags[3]));
    check("R3 sign", 32'(flags_o[4]), 32'(mflags[4]));
    check("R4 overflow", 32'(flags_o[5]), 32'(mflags[5]));
    check("R9 flags word", 32'(flags_o), 32'(mflags));
    sweep_conds();
  endtask

  function automatic logic [31:0] pick(input int k, input int sz);
    logic [31:0] msk, v;
    msk = (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    case (k)
      0: v = 32'h0;
      1: v = 32'h1;
      2: v = msk >> 1;
      3: v = (msk >> 1) + 32'h1;
      4: v = msk;
      5: v = 32'h0F;
      6: v = 32'h10;
      default: v = 32'h5A3C_96E1 & msk;
    endcase
    return v | (32'h9E3C_B6D1 & ~msk);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset clears the register
    check("R9 reset flags", 32'(flags_o), 32'h0);
    sweep_conds();
    rst_n = 1'b1;
    @(negedge clk);

    // directed boundary cases
    apply(0, 0, 32'h7E, 32'h2, 1'b1);        // R4 80h with overflow
    check("R4 7Eh+2", 32'(flags_o[5]), 32'h1);
    apply(1, 0, 32'h80, 32'h2, 1'b1);        // R4 7Eh with overflow
    check("R4 80h-2", 32'(flags_o[5]), 32'h1);
    apply(2, 1, 32'h5, 32'hA, 1'b1);         // R8 borrow on compare
    check("R8 5 vs 10 borrow", 32'(flags_o[0]), 32'h1);
    apply(0, 0, 32'h4F, 32'hB1, 1'b1);       // R2 carry set, zero result
    apply(3, 1, 32'hFFFF, 32'h0, 1'b1);      // R7 zero set, carry still 1
    check("R7 FFFFh+1 zero", 32'(flags_o[3]), 32'h1);
    check("R7 FFFFh+1 carry", 32'(flags_o[0]), 32'h1);
    // R9: without load the register ignores a new operation
    apply(0, 2, 32'h1, 32'h1, 1'b0);
    check("R9 no load", 32'(flags_o), 32'(mflags));

    // exhaustive sweep
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            apply(op, sz, pick(i, sz), pick(j, sz), 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule